// File: doc/BRIEF.md
# Extensible Pipeline Ownership Arbiter

This block decides, for every instruction that sits in the decode stage, which unit of an extensible processor owns it: the base datapath or one of several extension slots. Each candidate claims the instruction by pulling its own active-low recognize line. When several candidates claim the same instruction, a fixed scheme resolves the collision. The base datapath wins over ordinary slots. A slot whose high-priority bit is set wins over the base datapath. Ties among slots go to the lowest index.

A winning extension is told of its win by a one-cycle enable pulse. If it raises its acknowledge while that pulse is active, the block grants it the pipeline and asserts a stall for the whole time the acknowledge stays high. No new arbitration starts while an enable or a grant is outstanding, so extensions such as a debug agent can freeze the processor for as long as they need. If nobody claims, the base datapath keeps ownership so that its reserved-instruction trap can act.

Top module: `pipe_owner_arb`

## Requirements
- R1: A candidate claims the decode-stage instruction when its recognize line is 0. While the block is idle and no slot wins (including when nothing claims at all), `base_sel_o` is 1 in the same cycle.
- R2: When the base datapath claims and no claiming slot has its high-priority bit set, `base_sel_o` is 1 and no enable follows.
- R3: When a slot with its high-priority bit at 1 claims, it wins over the base datapath: `base_sel_o` is 0 in that cycle.
- R4: Among claiming high-priority slots the lowest index wins. When no high-priority slot claims and the base datapath does not claim, the lowest-index claiming slot wins.
- R5: In the cycle after a slot wins, exactly the winner's bit of `slot_en_o` is 1, for one cycle only. At most one enable bit is ever 1.
- R6: If the owner's acknowledge is 1 at the clock edge that ends the enable cycle, its `slot_gr_o` bit and `stall_o` are 1 from the next cycle. Otherwise the block returns to idle with no grant.
- R7: Grant and stall stay 1 while the owner's acknowledge stays 1, and both are 0 in the cycle after the edge at which it is sampled 0.
- R8: While an enable or grant is outstanding, claims are ignored, `base_sel_o` is 0, and acknowledges from slots other than the owner have no effect. At most one grant bit is ever 1.
- R9: During reset all enable and grant bits and `stall_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pipeline clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_ri_ni | input | 1 | Base datapath recognize, active low |
| slot_ri_ni | input | NUM_SLOTS | Per-slot recognize, active low |
| slot_hipri_i | input | NUM_SLOTS | Per-slot override-base priority bit |
| slot_ack_i | input | NUM_SLOTS | Per-slot acknowledge (hold request) |
| slot_en_o | output | NUM_SLOTS | Per-slot one-cycle accept pulse |
| slot_gr_o | output | NUM_SLOTS | Per-slot pipeline grant |
| base_sel_o | output | 1 | Base datapath owns the current instruction |
| stall_o | output | 1 | Processor pipeline stall |

## Verification
The assertions take for granted that a winning slot releases its recognize line after its enable pulse and that each acknowledge changes only on clock edges. They do not assume that slots other than the owner keep their acknowledge low. The bench drives every input just after the falling edge and holds it for the whole cycle. It deliberately raises acknowledges of slots that do not own the pipeline and reasserts claims during a grant, so that the ignore rules are tested at the ports.

// File: rtl/pipe_owner_arb_pkg.sv
package pipe_owner_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE   = 2'd0,
    OWN_NOTIFY = 2'd1,
    OWN_HOLD   = 2'd2
  } own_state_e;
endpackage

// File: rtl/arb_claim_decode.sv
module arb_claim_decode #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 base_ri_ni,
  input  logic [NUM_SLOTS-1:0] slot_ri_ni,
  input  logic [NUM_SLOTS-1:0] slot_hipri_i,
  output logic                 base_claim_o,
  output logic [NUM_SLOTS-1:0] any_req_o,
  output logic [NUM_SLOTS-1:0] hi_req_o
);
  assign base_claim_o = ~base_ri_ni;
  assign any_req_o    = ~slot_ri_ni;
  assign hi_req_o     = ~slot_ri_ni & slot_hipri_i;
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  logic [NUM_REQ:0] seen;
  assign seen[0] = 1'b0;

  // lowest index first
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_chain
    assign gnt_o[g]    = req_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req_i[g];
  end

  assign any_o = seen[NUM_REQ];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (gnt_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/arb_own_fsm.sv
module arb_own_fsm
  import pipe_owner_arb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 slot_win_i,
  input  logic [IDX_W-1:0]     win_idx_i,
  input  logic [NUM_SLOTS-1:0] ack_i,
  output logic                 idle_o,
  output logic [NUM_SLOTS-1:0] en_o,
  output logic [NUM_SLOTS-1:0] gr_o,
  output logic                 stall_o
);
  own_state_e       state_q, state_d;
  logic [IDX_W-1:0] owner_q, owner_d;
  logic             owner_ack;

  assign owner_ack = ack_i[owner_q];

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    unique case (state_q)
      OWN_IDLE: begin
        if (slot_win_i) begin
          state_d = OWN_NOTIFY;
          owner_d = win_idx_i;
        end
      end
      OWN_NOTIFY: state_d = owner_ack ? OWN_HOLD : OWN_IDLE;
      OWN_HOLD:   state_d = owner_ack ? OWN_HOLD : OWN_IDLE;
      default:    state_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OWN_IDLE;
      owner_q <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_out
    assign en_o[g] = (state_q == OWN_NOTIFY) && (owner_q == IDX_W'(g));
    assign gr_o[g] = (state_q == OWN_HOLD)   && (owner_q == IDX_W'(g));
  end

  assign idle_o  = (state_q == OWN_IDLE);
  assign stall_o = (state_q == OWN_HOLD);
endmodule

// File: rtl/pipe_owner_arb.sv
module pipe_owner_arb #(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 base_ri_ni,
  input  logic [NUM_SLOTS-1:0] slot_ri_ni,
  input  logic [NUM_SLOTS-1:0] slot_hipri_i,
  input  logic [NUM_SLOTS-1:0] slot_ack_i,
  output logic [NUM_SLOTS-1:0] slot_en_o,
  output logic [NUM_SLOTS-1:0] slot_gr_o,
  output logic                 base_sel_o,
  output logic                 stall_o
);
  logic                 base_claim;
  logic [NUM_SLOTS-1:0] any_req, hi_req;
  logic [NUM_SLOTS-1:0] hi_gnt, any_gnt;
  logic [IDX_W-1:0]     hi_idx, any_idx, win_idx;
  logic                 hi_any, req_any, slot_win, idle;

  arb_claim_decode #(.NUM_SLOTS(NUM_SLOTS)) i_decode (
    .base_ri_ni   (base_ri_ni),
    .slot_ri_ni   (slot_ri_ni),
    .slot_hipri_i (slot_hipri_i),
    .base_claim_o (base_claim),
    .any_req_o    (any_req),
    .hi_req_o     (hi_req)
  );

  arb_prio_pick #(.NUM_REQ(NUM_SLOTS)) i_pick_hi (
    .req_i (hi_req),
    .gnt_o (hi_gnt),
    .idx_o (hi_idx),
    .any_o (hi_any)
  );

  arb_prio_pick #(.NUM_REQ(NUM_SLOTS)) i_pick_any (
    .req_i (any_req),
    .gnt_o (any_gnt),
    .idx_o (any_idx),
    .any_o (req_any)
  );

  // high priority beats base; base beats normal slots
  assign slot_win = hi_any | (req_any & ~base_claim);
  assign win_idx  = hi_any ? hi_idx : any_idx;

  arb_own_fsm #(.NUM_SLOTS(NUM_SLOTS)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_win_i (slot_win),
    .win_idx_i  (win_idx),
    .ack_i      (slot_ack_i),
    .idle_o     (idle),
    .en_o       (slot_en_o),
    .gr_o       (slot_gr_o),
    .stall_o    (stall_o)
  );

  assign base_sel_o = idle & ~slot_win;

  logic unused_gnt;
  assign unused_gnt = ^{hi_gnt, any_gnt};
endmodule

// File: rtl/pipe_owner_arb_chk.sv
module pipe_owner_arb_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 base_ri_ni,
  input logic [NUM_SLOTS-1:0] slot_ri_ni,
  input logic [NUM_SLOTS-1:0] slot_hipri_i,
  input logic [NUM_SLOTS-1:0] slot_ack_i,
  input logic [NUM_SLOTS-1:0] slot_en_o,
  input logic [NUM_SLOTS-1:0] slot_gr_o,
  input logic                 base_sel_o,
  input logic                 stall_o
);
  logic busy, hi_claim;
  assign busy     = (|slot_en_o) | (|slot_gr_o);
  assign hi_claim = |(~slot_ri_ni & slot_hipri_i);

  assert_idle_default_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && (&slot_ri_ni)) |-> base_sel_o);

  assert_base_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !base_ri_ni && !hi_claim) |-> base_sel_o);

  assert_hipri_override_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_claim |-> !base_sel_o);

  assert_en_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_en_o));

  assert_en_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_en_o) |=> !(|slot_en_o));

  assert_gr_needs_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(|(slot_en_o & slot_ack_i)));

  assert_gr_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|slot_gr_o) && !(|(slot_gr_o & slot_ack_i))) |=> !(|slot_gr_o));

  assert_gr_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(slot_gr_o & slot_ack_i)) |=> $stable(slot_gr_o));

  assert_gr_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_gr_o));

  assert_busy_no_base_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !base_sel_o);

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R9: assert (!stall_o);
  end
endmodule

bind pipe_owner_arb pipe_owner_arb_chk #(.NUM_SLOTS(NUM_SLOTS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .base_ri_ni   (base_ri_ni),
  .slot_ri_ni   (slot_ri_ni),
  .slot_hipri_i (slot_hipri_i),
  .slot_ack_i   (slot_ack_i),
  .slot_en_o    (slot_en_o),
  .slot_gr_o    (slot_gr_o),
  .base_sel_o   (base_sel_o),
  .stall_o      (stall_o)
);

// File: tb/test_pipe_owner_arb.sv
`timescale 1ns/1ps
module test_pipe_owner_arb;
  localparam int N  = 4;
  localparam int EW = 2*N + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         base_ri_n;
  logic [N-1:0] ri_n, hipri, ack, en, gr;
  logic         base_sel, stall;

  pipe_owner_arb #(.NUM_SLOTS(N)) i_pipe_owner_arb (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .base_ri_ni   (base_ri_n),
    .slot_ri_ni   (ri_n),
    .slot_hipri_i (hipri),
    .slot_ack_i   (ack),
    .slot_en_o    (en),
    .slot_gr_o    (gr),
    .base_sel_o   (base_sel),
    .stall_o      (stall)
  );

  logic [EW-1:0] exp_q[$];
  string         tag_q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state: 0 idle, 1 enable, 2 hold
  int m_st  = 0;
  int m_own = 0;

  task automatic step(input logic b_ri, input logic [N-1:0] r, input logic [N-1:0] h,
                      input logic [N-1:0] a, input string tag);
    logic [N-1:0] e_en, e_gr;
    logic         e_st, e_base;
    int           win;
    @(negedge clk);
    base_ri_n = b_ri; ri_n = r; hipri = h; ack = a;
    e_en = '0; e_gr = '0; e_st = 1'b0; e_base = 1'b0;
    if (m_st == 0) begin
      win = -1;
      for (int i = 0; i < N; i++) if (!r[i] && h[i] && win < 0) win = i;
      if (win < 0 && b_ri) for (int i = 0; i < N; i++) if (!r[i] && win < 0) win = i;
      e_base = (win < 0);
      if (win >= 0) begin m_st = 1; m_own = win; end
    end else if (m_st == 1) begin
      e_en[m_own] = 1'b1;
      m_st = a[m_own] ? 2 : 0;
    end else begin
      e_gr[m_own] = 1'b1;
      e_st = 1'b1;
      m_st = a[m_own] ? 2 : 0;
    end
    exp_q.push_back({e_en, e_gr, e_st, e_base});
    tag_q.push_back(tag);
  endtask

  // monitor: compares just after each falling edge
  always @(negedge clk) begin
    logic [EW-1:0] e, act;
    string t;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = {en, gr, stall, base_sel};
      total++;
      if (act !== e) begin
        bad++;
        $display("FAIL %s act{en,gr,stall,base}=%b exp=%b", t, act, e);
      end
    end
  end

  initial begin
    base_ri_n = 1'b1; ri_n = '1; hipri = '0; ack = '0;
    repeat (3) @(negedge clk);
    total++;
    if ({en, gr, stall} !== '0) begin
      bad++;
      $display("FAIL R9 act=%b exp=%b", {en, gr, stall}, {(2*N+1){1'b0}});
    end
    rst_n = 1'b1;

    step(1'b1, 4'b1111, 4'b0000, 4'b0000, "R1 idle no claim");
    step(1'b0, 4'b1111, 4'b0000, 4'b0000, "R1 base only");
    step(1'b0, 4'b1011, 4'b0000, 4'b0000, "R2 base beats normal slot2");
    step(1'b0, 4'b1101, 4'b0100, 4'b0000, "R2 hipri slot not claiming");
    // hipri slot3 beats base, no ack -> no grant
    step(1'b0, 4'b0111, 4'b1000, 4'b0000, "R3 hipri slot3 over base");
    step(1'b1, 4'b1111, 4'b1000, 4'b0000, "R5 en slot3");
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, "R6 no ack back to idle");
    // two hipri slots -> slot1, then hold
    step(1'b0, 4'b0101, 4'b1010, 4'b0000, "R4 lowest hipri");
    step(1'b1, 4'b1111, 4'b0000, 4'b0010, "R5 en slot1");
    step(1'b1, 4'b1111, 4'b0000, 4'b0010, "R6 grant slot1");
    step(1'b0, 4'b0000, 4'b1111, 4'b1111, "R8 claims ignored in hold");
    step(1'b0, 4'b0000, 4'b1111, 4'b1011, "R7 hold while ack");
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, "R7 ack dropped");
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, "R7 grant released");
    // normal slots without base -> slot2, non-owner ack
    step(1'b1, 4'b0011, 4'b0000, 4'b0000, "R4 lowest normal");
    step(1'b0, 4'b0000, 4'b1111, 4'b1001, "R8 foreign ack in enable");
    step(1'b1, 4'b1111, 4'b0000, 4'b1001, "R8 no grant from foreign ack");
    // hipri slot0 with base and normal slot1
    step(1'b0, 4'b1100, 4'b0001, 4'b0000, "R3 hipri slot0");
    step(1'b1, 4'b1111, 4'b0000, 4'b0001, "R5 en slot0");
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, "R6 ack only in enable cycle");
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, "R7 single cycle grant ends");
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, "R1 idle again");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule